// File: doc/BRIEF.md
# Pipelined Sobel Derivative Stage

This block computes one directional derivative of a 3x3 Sobel window. It takes two triplets of 8-bit unsigned pixels, one from each side of the window, and gives the weighted difference of the two. In each triplet the centre pixel counts twice. The result is an 11-bit two's-complement number. An edge detector uses two copies of the block, one horizontal and one vertical, and feeds their results to the magnitude and direction logic that follows.

The adder tree is split so that each triplet is summed on its own. The centre pixel is doubled by a wiring shift. The two sums meet only in a final subtract. There is a register between every pair of levels, which keeps the critical path to one narrow adder. A valid strobe travels with the data through a matching delay line. One new set of pixels can be accepted on every clock.

Top module: `sobel_deriv_stage`

## Requirements
- R1: When `out_valid` is high, `p_out` equals (a1 + 2·b1 + c1) − (a2 + 2·b2 + c2) for the inputs that went with that result, as an 11-bit two's-complement value.
- R2: Inputs captured on rising edge N give their result on `p_out` right after rising edge N+3. This is four register stages, counting the capturing edge as the first.
- R3: `out_valid` is `in_valid` delayed by exactly the same four stages. A result appears only for inputs that were presented with `in_valid` high.
- R4: A synchronous active-high `rst` clears every valid stage. `out_valid` is low on the cycle after any reset edge. Inputs captured while `rst` is high, or still in flight when `rst` rises, never produce a result.
- R5: The extreme results +1020 (first triplet all 255, second all 0) and −1020 (the reverse) come out without wrap-around. No valid result lies outside ±1020.
- R6: The stage accepts a new input set on every clock cycle. Back-to-back inputs give back-to-back results, in order.
- R7: Gaps in `in_valid` show up as gaps of the same length and position in `out_valid`. The results on either side of a gap stay correct.
- R8: The centre pixel of each triplet carries weight 2 and the outer pixels weight 1. A single 1 on b1 gives +2, on a1 or c1 gives +1, on b2 gives −2, and on a2 or c2 gives −1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers change on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | The six pixel inputs hold a sample this cycle |
| a1 | input | 8 | First triplet, outer pixel |
| b1 | input | 8 | First triplet, centre pixel (weight 2) |
| c1 | input | 8 | First triplet, other outer pixel |
| a2 | input | 8 | Second triplet, outer pixel |
| b2 | input | 8 | Second triplet, centre pixel (weight 2) |
| c2 | input | 8 | Second triplet, other outer pixel |
| out_valid | output | 1 | `p_out` holds a result this cycle |
| p_out | output | 11 | Signed derivative, two's complement |

## Verification
Every result is due exactly three rising edges after the edge that captures its inputs. For each input set it presents, the driver stores the expected value together with that edge number. The monitor counts rising edges and samples the outputs 5 ns after each one. It compares value and timing at once, so a result that comes early, comes late, is missing or is not expected is reported against R2 or R3. After each reset, the edges in which no result may appear are checked one by one.

// File: rtl/sobel_deriv_pkg.sv
package sobel_deriv_pkg;

    // Pixel width; every other width below follows from it.
    localparam int PIX_W   = 8;
    // One outer pair (a+c) or a doubled centre (2b).
    localparam int PAIR_W  = PIX_W + 1;
    // Weighted triplet sum, at most 4*(2^PIX_W - 1).
    localparam int SUM_W   = PIX_W + 2;
    // Signed difference of two triplet sums.
    localparam int RES_W   = PIX_W + 3;
    // Register stages from input to output.
    localparam int LATENCY = 4;
    // Largest possible magnitude of a result.
    localparam int RES_MAX = 4 * ((1 << PIX_W) - 1);

    typedef logic [PIX_W-1:0]        pix_t;
    typedef logic [SUM_W-1:0]        tsum_t;
    typedef logic signed [RES_W-1:0] res_t;

    typedef struct packed {
        pix_t edge_lo;
        pix_t centre;
        pix_t edge_hi;
    } triplet_t;

    typedef struct packed {
        logic [PAIR_W-1:0] outer_sum;
        logic [PAIR_W-1:0] centre_x2;
    } partial_t;

    // First level: add the two outer pixels; double the centre by wiring.
    function automatic partial_t split_triplet(input triplet_t t);
        partial_t p;
        p.outer_sum = {1'b0, t.edge_lo} + {1'b0, t.edge_hi};
        p.centre_x2 = {t.centre, 1'b0};
        return p;
    endfunction

    // Second level: combine the two partials into the weighted sum.
    function automatic tsum_t join_partial(input partial_t p);
        return {1'b0, p.outer_sum} + {1'b0, p.centre_x2};
    endfunction

    // Final level: signed difference of two unsigned sums.
    function automatic res_t sum_diff(input tsum_t pos, input tsum_t neg);
        return $signed({1'b0, pos}) - $signed({1'b0, neg});
    endfunction

endpackage

// File: rtl/sd_triplet_sum.sv
module sd_triplet_sum
    import sobel_deriv_pkg::*;
(
    input  logic     clk,
    input  triplet_t trip,
    output tsum_t    sum_q
);
    partial_t part_q;

    // Stage 1: outer pair sum and doubled centre, registered side by side
    always_ff @(posedge clk) begin
        part_q <= split_triplet(trip);
    end

    // Stage 2: weighted triplet sum
    always_ff @(posedge clk) begin
        sum_q <= join_partial(part_q);
    end
endmodule

// File: rtl/sd_diff_out.sv
module sd_diff_out
    import sobel_deriv_pkg::*;
(
    input  logic  clk,
    input  tsum_t pos_sum,
    input  tsum_t neg_sum,
    output res_t  res_q
);
    res_t diff_q;

    // Stage 3: the only subtraction in the datapath
    always_ff @(posedge clk) begin
        diff_q <= sum_diff(pos_sum, neg_sum);
    end

    // Stage 4: output register
    always_ff @(posedge clk) begin
        res_q <= diff_q;
    end
endmodule

// File: rtl/sd_valid_pipe.sv
module sd_valid_pipe #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic vin,
    output logic vout
);
    logic [DEPTH:0] chain;

    assign chain[0] = vin;

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s+1] <= 1'b0;
                else     chain[s+1] <= chain[s];
            end
        end
    endgenerate

    assign vout = chain[DEPTH];
endmodule

// File: rtl/sobel_deriv_stage.sv
module sobel_deriv_stage
    import sobel_deriv_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [PIX_W-1:0]        a1,
    input  logic [PIX_W-1:0]        b1,
    input  logic [PIX_W-1:0]        c1,
    input  logic [PIX_W-1:0]        a2,
    input  logic [PIX_W-1:0]        b2,
    input  logic [PIX_W-1:0]        c2,
    output logic                    out_valid,
    output logic signed [RES_W-1:0] p_out
);
    localparam int N_SIDES = 2;

    triplet_t trips [N_SIDES];
    tsum_t    sums  [N_SIDES];

    assign trips[0] = '{edge_lo: a1, centre: b1, edge_hi: c1};
    assign trips[1] = '{edge_lo: a2, centre: b2, edge_hi: c2};

    // Two independent triplet sums, built in parallel
    generate
        for (genvar g = 0; g < N_SIDES; g++) begin : g_side
            sd_triplet_sum u_sum (
                .clk   (clk),
                .trip  (trips[g]),
                .sum_q (sums[g])
            );
        end
    endgenerate

    sd_diff_out u_diff (
        .clk     (clk),
        .pos_sum (sums[0]),
        .neg_sum (sums[1]),
        .res_q   (p_out)
    );

    sd_valid_pipe #(.DEPTH(LATENCY)) u_vld (
        .clk  (clk),
        .rst  (rst),
        .vin  (in_valid),
        .vout (out_valid)
    );
endmodule

// File: rtl/sd_deriv_chk.sv
module sd_deriv_chk
    import sobel_deriv_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [PIX_W-1:0]        a1,
    input logic [PIX_W-1:0]        b1,
    input logic [PIX_W-1:0]        c1,
    input logic [PIX_W-1:0]        a2,
    input logic [PIX_W-1:0]        b2,
    input logic [PIX_W-1:0]        c2,
    input logic                    out_valid,
    input logic signed [RES_W-1:0] p_out
);
    // Edges since the last reset, saturating
    logic [2:0] age;
    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (age != 3'd7) age <= age + 3'd1;
    end

    int ref_val;
    always_comb begin
        ref_val = (int'(a1) + 2*int'(b1) + int'(c1))
                - (int'(a2) + 2*int'(b2) + int'(c2));
    end

    // R1 R2
    value_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd4 && out_valid) |-> (int'(p_out) == $past(ref_val, 4)));

    // R3
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

    // R4
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R4
    post_reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (age < 3'd4) |-> !out_valid);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(p_out) <= RES_MAX && int'(p_out) >= -RES_MAX));
endmodule

bind sobel_deriv_stage sd_deriv_chk u_chk (.*);

// File: tb/tb_sobel_deriv_stage.sv
module tb_sobel_deriv_stage;
    import sobel_deriv_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] a1 = '0, b1 = '0, c1 = '0, a2 = '0, b2 = '0, c2 = '0;
    logic out_valid;
    logic signed [10:0] p_out;

    sobel_deriv_stage dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a1(a1), .b1(b1), .c1(c1), .a2(a2), .b2(b2), .c2(c2),
        .out_valid(out_valid), .p_out(p_out)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        int    val;
        int    due;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Monitor / scoreboard: sample 5 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #5;
            while (exp_q.size() > 0 && exp_q[0].due < cyc) begin
                check(1'b0, {exp_q[0].req, " R2 missing result"}, 0, exp_q[0].val);
                void'(exp_q.pop_front());
            end
            if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                check(out_valid == 1'b1, {exp_q[0].req, " R3 out_valid"}, int'(out_valid), 1);
                check(int'(p_out) == exp_q[0].val, {exp_q[0].req, " R1 value"}, int'(p_out), exp_q[0].val);
                void'(exp_q.pop_front());
            end else if (out_valid) begin
                check(1'b0, "R3 unexpected out_valid", 1, 0);
            end
        end
    end

    // Drive one cycle of inputs; push the expected result when it counts
    task automatic drive(input int va1, input int vb1, input int vc1,
                         input int va2, input int vb2, input int vc2,
                         input bit v, input bit push, input string req);
        exp_t e;
        @(negedge clk);
        a1 = 8'(va1); b1 = 8'(vb1); c1 = 8'(vc1);
        a2 = 8'(va2); b2 = 8'(vb2); c2 = 8'(vc2);
        in_valid = v;
        if (v && push) begin
            e.val = (va1 + 2*vb1 + vc1) - (va2 + 2*vb2 + vc2);
            e.due = cyc + 4;
            e.req = req;
            exp_q.push_back(e);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 1'b0, 1'b0, "");
    endtask

    task automatic quiet_after_reset(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #5;
            check(out_valid == 1'b0, "R4 out_valid after reset", int'(out_valid), 0);
        end
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        // Reset with valid inputs held high: they must be discarded (R4)
        @(negedge clk);
        in_valid = 1'b1; a1 = 8'd200; b1 = 8'd10;
        repeat (3) @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        quiet_after_reset(5);

        // R8: weights of individual pixels
        drive(0, 1, 0, 0, 0, 0, 1'b1, 1'b1, "R8 b1");
        drive(1, 0, 0, 0, 0, 0, 1'b1, 1'b1, "R8 a1");
        drive(0, 0, 1, 0, 0, 0, 1'b1, 1'b1, "R8 c1");
        drive(0, 0, 0, 0, 1, 0, 1'b1, 1'b1, "R8 b2");
        drive(0, 0, 0, 1, 0, 0, 1'b1, 1'b1, "R8 a2");
        drive(0, 0, 0, 0, 0, 1, 1'b1, 1'b1, "R8 c2");
        // R5: extremes and zero
        drive(255, 255, 255, 0, 0, 0, 1'b1, 1'b1, "R5 +max");
        drive(0, 0, 0, 255, 255, 255, 1'b1, 1'b1, "R5 -max");
        drive(255, 255, 255, 255, 255, 255, 1'b1, 1'b1, "R1 equal");
        drive(0, 0, 0, 0, 0, 0, 1'b1, 1'b1, "R1 zero");
        drive(10, 20, 30, 40, 50, 60, 1'b1, 1'b1, "R1 ramp");
        idle(6);

        // R6: back-to-back pseudo-random stream
        lfsr = 16'hACE1;
        for (int i = 0; i < 40; i++) begin
            int r[6];
            for (int k = 0; k < 6; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                r[k] = int'(lfsr[7:0]);
            end
            drive(r[0], r[1], r[2], r[3], r[4], r[5], 1'b1, 1'b1, "R6 stream");
        end

        // R7: bubbles of differing length
        for (int i = 0; i < 12; i++) begin
            bit v = (i % 3 != 1) && (i != 7);
            drive(i * 17 % 256, i * 5, 255 - i, i, 3 * i, 128, v, 1'b1, "R7 bubble");
        end
        idle(6);

        // R4: reset while results are in flight
        drive(90, 90, 90, 0, 0, 0, 1'b1, 1'b0, "");
        drive(0, 0, 0, 90, 90, 90, 1'b1, 1'b0, "");
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        quiet_after_reset(6);

        // R2: single result after reset, timed by the scoreboard
        drive(3, 4, 5, 1, 1, 1, 1'b1, 1'b1, "R2 single");
        idle(8);

        check(exp_q.size() == 0, "R3 all results delivered", exp_q.size(), 0);
        finish_run();
    end
endmodule